// File: doc/BRIEF.md
# Injected-Event Fault Escalation Controller

This controller follows the delivery of a single event that a hypervisor injects into a guest on entry. It latches the event's interruption type and vector. It then watches a stream of nested-exception reports that arrive while the event, or a later exception, is being delivered. For each report it decides one of four things: the nested exception exits to the hypervisor because its exception-bitmap bit is set; it escalates to a double fault; a fault raised while the double-fault handler is being reached becomes a triple-fault exit; or it is delivered normally with an error code. That error code has its external-event flag (bit 0) chosen from the injected type and from how deep the nested chain has gone.

For every delivery that starts, the block gives the address of the handler-table slot it reads. The slot is 8 bytes wide in protected mode and 4 bytes wide in real mode, and no error code is ever pushed in real mode. When the outcome is an exit, the block strobes an exit indication for one cycle. It raises a save flag when the injected event has to be recorded as the vectoring information. It then holds a done indication with an outcome code until the surrounding logic acknowledges it.

The states are IDLE (waiting for an injection), DELIVER (the injected event is in flight), NESTED (a nested exception is in flight), DOUBLE_FAULT (a double fault is in flight), EXIT_BITMAP and EXIT_TRIPLE (one-cycle exit announcements) and DONE (holding the outcome until acknowledged).

The transitions are:
- IDLE to DELIVER on a start with a valid type.
- IDLE to DOUBLE_FAULT when the injected event is a hardware exception with vector 8.
- DELIVER or NESTED to NESTED on a plain nested exception.
- DELIVER or NESTED to DOUBLE_FAULT on a contributory pair.
- DELIVER, NESTED or DOUBLE_FAULT to EXIT_BITMAP on a bitmap hit.
- DOUBLE_FAULT to EXIT_TRIPLE on a report that misses the bitmap.
- DELIVER, NESTED or DOUBLE_FAULT to DONE on delivery completion.
- Both exit states to DONE after one cycle.
- DONE to IDLE on acknowledge.

Top module: `evx_escalator`

## Requirements
- R1: After reset, `busy`, `done`, `ec_push`, `entry_valid`, `exit_valid`, `exit_triple` and `save_vectoring` are all 0.
- R2: A start is accepted only for type codes 0 (external interrupt), 2 (NMI), 3 (hardware exception), 4 (software interrupt), 5 (privileged software exception) and 6 (software exception). A start with code 1 or 7 is ignored: `busy` and `entry_valid` stay 0.
- R3: The injected event never causes an exit, whatever the bitmap holds. One cycle after an accepted start, `entry_valid` pulses with `entry_addr` = base + 8*vector in protected mode or base + 4*vector in real mode. If an error code was requested in protected mode, that code is pushed unchanged in the same cycle.
- R4: For the first nested exception that is delivered normally, EXT is 1 for type codes 0, 2, 3 and 5 and 0 for codes 4 and 6.
- R5: Every nested exception delivered normally after the first one pushes with EXT = 1.
- R6: A double fault is produced when the exception in flight and the newly reported nested exception both belong to the contributory set {0,10,11,12,13,14}. An injected event counts as in flight for this test only when its type code is 3. A double fault pushes 0000h and pulses `entry_valid` at base + 8*8.
- R7: A nested exception reported during double-fault delivery that misses the bitmap pulses `exit_valid` and `exit_triple` for exactly one cycle. `done` follows with outcome 2.
- R8: An injected hardware exception with vector 8 enters double-fault delivery directly, so its first nested exception that misses the bitmap gives a triple-fault exit.
- R9: A nested vector below 32 whose bitmap bit is 1 pulses `exit_valid` (with `exit_triple` 0) for one cycle, followed by `done` with outcome 1. Vectors 32 and above never hit the bitmap.
- R10: `save_vectoring` is 1 during a bitmap exit only when the exiting exception is the first nested exception of the injection, including the first one after an injected double fault.
- R11: In real mode no error code is ever pushed: not for the injected event, not for a nested exception, not for a double fault.
- R12: `dlv_ok` ends delivery with `done` = 1 and outcome 0 one cycle later. A nested report in the same cycle takes priority over `dlv_ok`. `done` holds until `ack`, and the cycle after `ack` the block is idle.
- R13: A normally delivered nested exception pushes its reported code with bit 0 replaced by EXT, and pushes only when `nest_has_ec` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_start | input | 1 | Begin an injection (sampled in IDLE) |
| inj_type | input | 3 | Interruption type code of the injected event |
| inj_vector | input | 8 | Vector of the injected event |
| inj_ec_req | input | 1 | Injected event requests an error-code push |
| inj_ec | input | 16 | Error code of the injected event |
| real_mode | input | 1 | Guest enters with protection disabled |
| table_base | input | 32 | Base address of the handler table |
| exc_bitmap | input | 32 | Exit-selection bit per exception vector |
| nest_valid | input | 1 | A nested exception is reported this cycle |
| nest_vector | input | 8 | Vector of the nested exception |
| nest_has_ec | input | 1 | Nested exception carries an error code |
| nest_ec | input | 16 | Error code of the nested exception (bit 0 overwritten) |
| dlv_ok | input | 1 | Current delivery completed without a fault |
| ack | input | 1 | Acknowledge of the held outcome |
| busy | output | 1 | An injection is in progress |
| ec_push | output | 1 | One-cycle strobe: an error code is pushed |
| ec_value | output | 16 | Error code being pushed |
| entry_valid | output | 1 | One-cycle strobe: a handler slot is read |
| entry_addr | output | 32 | Address of that handler slot |
| exit_valid | output | 1 | One-cycle strobe: delivery ends in an exit |
| exit_triple | output | 1 | The exit is a triple fault |
| save_vectoring | output | 1 | The injected event must be saved as vectoring information |
| done | output | 1 | Outcome held until acknowledged |
| outcome | output | 2 | 0 delivered, 1 bitmap exit, 2 triple-fault exit |

## Verification
The bench builds the block with its default parameters: 8-bit vectors, a 32-entry bitmap, the contributory mask {0,10..14} and vector 8 as the double-fault vector. With these values the bench can sweep every valid and reserved type code against the EXT rules. It can also try every ordered pair of vectors 0..31 as an injected hardware exception followed by a nested exception, which covers each double-fault decision and each triple-fault follow-up. Finally it can walk every bitmap position, plus vectors past the bitmap, at the first and second nesting levels, and repeat the addressing in real mode.

// File: rtl/evx_pkg.sv
package evx_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_DELIVER     = 3'd1,
        ST_NESTED      = 3'd2,
        ST_DOUBLE      = 3'd3,
        ST_EXIT_TRIPLE = 3'd4,
        ST_EXIT_BITMAP = 3'd5,
        ST_DONE        = 3'd6
    } evx_state_e;

    // Outcome codes held in DONE
    typedef enum logic [1:0] {
        OC_DELIVERED = 2'd0,
        OC_BITMAP    = 2'd1,
        OC_TRIPLE    = 2'd2
    } evx_outcome_e;

    // Interruption type codes
    localparam logic [2:0] IT_EXTINT = 3'd0;
    localparam logic [2:0] IT_NMI    = 3'd2;
    localparam logic [2:0] IT_HWEXC  = 3'd3;
    localparam logic [2:0] IT_SWINT  = 3'd4;
    localparam logic [2:0] IT_PRIVSW = 3'd5;
    localparam logic [2:0] IT_SWEXC  = 3'd6;

endpackage

// File: rtl/evx_ext_sel.sv
// Classifies the injected type and chooses the external-event flag
// for an error code, given whether this is the first nesting level.
module evx_ext_sel
    import evx_pkg::*;
(
    input  logic [2:0] itype,
    input  logic       first_level,
    output logic       ext_bit,
    output logic       type_ok
);

    logic ext_by_type;

    always_comb begin
        ext_by_type = 1'b1;
        type_ok     = 1'b0;
        unique case (itype)
            IT_EXTINT, IT_NMI, IT_HWEXC, IT_PRIVSW: begin
                ext_by_type = 1'b1;
                type_ok     = 1'b1;
            end
            IT_SWINT, IT_SWEXC: begin
                ext_by_type = 1'b0;
                type_ok     = 1'b1;
            end
            default: begin
                ext_by_type = 1'b1;
                type_ok     = 1'b0;
            end
        endcase
    end

    // Deeper levels always mark the code as externally caused
    assign ext_bit = first_level ? ext_by_type : 1'b1;

endmodule

// File: rtl/evx_vec_class.sv
// Decodes a vector against the exit bitmap and the contributory class.
module evx_vec_class #(
    parameter int                VEC_W        = 8,
    parameter int                BMAP_W       = 32,
    parameter logic [BMAP_W-1:0] CONTRIB_MASK = 32'h0000_7C01
) (
    input  logic [VEC_W-1:0]  vector,
    input  logic [BMAP_W-1:0] bitmap,
    output logic              bmap_hit,
    output logic              contrib
);

    logic [BMAP_W-1:0] sel;

    // One-hot decode; vectors at or past BMAP_W select nothing
    for (genvar i = 0; i < BMAP_W; i++) begin : g_dec
        assign sel[i] = (32'(vector) == i);
    end

    assign bmap_hit = |(sel & bitmap);
    assign contrib  = |(sel & CONTRIB_MASK);

endmodule

// File: rtl/evx_entry_calc.sv
// Handler-table slot address: wide gates when protected, narrow when real.
module evx_entry_calc #(
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int PM_SHIFT = 3,
    parameter int RM_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vector,
    input  logic              real_mode,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] vext;
    logic [ADDR_W-1:0] offs;

    assign vext = ADDR_W'(vector);
    assign offs = real_mode ? (vext << RM_SHIFT) : (vext << PM_SHIFT);
    assign addr = base + offs;

endmodule

// File: rtl/evx_escalator.sv
module evx_escalator
    import evx_pkg::*;
#(
    parameter int                VEC_W        = 8,
    parameter int                EC_W         = 16,
    parameter int                ADDR_W       = 32,
    parameter int                BMAP_W       = 32,
    parameter int                DF_VEC       = 8,
    parameter logic [BMAP_W-1:0] CONTRIB_MASK = 32'h0000_7C01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inj_start,
    input  logic [2:0]        inj_type,
    input  logic [VEC_W-1:0]  inj_vector,
    input  logic              inj_ec_req,
    input  logic [EC_W-1:0]   inj_ec,
    input  logic              real_mode,
    input  logic [ADDR_W-1:0] table_base,
    input  logic [BMAP_W-1:0] exc_bitmap,
    input  logic              nest_valid,
    input  logic [VEC_W-1:0]  nest_vector,
    input  logic              nest_has_ec,
    input  logic [EC_W-1:0]   nest_ec,
    input  logic              dlv_ok,
    input  logic              ack,
    output logic              busy,
    output logic              ec_push,
    output logic [EC_W-1:0]   ec_value,
    output logic              entry_valid,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              exit_valid,
    output logic              exit_triple,
    output logic              save_vectoring,
    output logic              done,
    output logic [1:0]        outcome
);

    localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

    evx_state_e state_q, state_d;

    // Injection context
    logic [2:0]        itype_q;
    logic              real_q;
    logic [ADDR_W-1:0] base_q;
    logic              cur_contrib_q, contrib_d;
    logic              df_inj_q, df_inj_d;
    logic              svec_q, svec_d;
    evx_outcome_e      outc_q, outc_d;

    // Per-cycle decisions
    logic              push_d;
    logic [EC_W-1:0]   pushv_d;
    logic              entry_d;
    logic [VEC_W-1:0]  evec_d;

    // Shared classifiers
    logic              in_idle;
    logic [VEC_W-1:0]  cls_vec;
    logic              vec_hit, vec_contrib;
    logic [2:0]        type_sel;
    logic              ext_bit, type_ok;
    logic [ADDR_W-1:0] base_sel;
    logic              real_sel;
    logic [ADDR_W-1:0] addr_d;

    assign in_idle  = (state_q == ST_IDLE);
    assign cls_vec  = in_idle ? inj_vector : nest_vector;
    assign type_sel = in_idle ? inj_type : itype_q;
    assign base_sel = in_idle ? table_base : base_q;
    assign real_sel = in_idle ? real_mode : real_q;

    evx_vec_class #(
        .VEC_W       (VEC_W),
        .BMAP_W      (BMAP_W),
        .CONTRIB_MASK(CONTRIB_MASK)
    ) u_class (
        .vector  (cls_vec),
        .bitmap  (exc_bitmap),
        .bmap_hit(vec_hit),
        .contrib (vec_contrib)
    );

    evx_ext_sel u_ext (
        .itype      (type_sel),
        .first_level(state_q == ST_DELIVER),
        .ext_bit    (ext_bit),
        .type_ok    (type_ok)
    );

    evx_entry_calc #(
        .VEC_W (VEC_W),
        .ADDR_W(ADDR_W)
    ) u_entry (
        .base     (base_sel),
        .vector   (evec_d),
        .real_mode(real_sel),
        .addr     (addr_d)
    );

    // Next state and per-cycle decisions
    always_comb begin
        state_d   = state_q;
        contrib_d = cur_contrib_q;
        df_inj_d  = df_inj_q;
        svec_d    = svec_q;
        outc_d    = outc_q;
        push_d    = 1'b0;
        pushv_d   = '0;
        entry_d   = 1'b0;
        evec_d    = nest_vector;
        unique case (state_q)
            ST_IDLE: begin
                if (inj_start && type_ok) begin
                    entry_d   = 1'b1;
                    evec_d    = inj_vector;
                    push_d    = inj_ec_req && !real_mode;
                    pushv_d   = inj_ec;
                    svec_d    = 1'b0;
                    outc_d    = OC_DELIVERED;
                    contrib_d = (inj_type == IT_HWEXC) && vec_contrib;
                    if (inj_type == IT_HWEXC && inj_vector == DF_V) begin
                        state_d  = ST_DOUBLE;
                        df_inj_d = 1'b1;
                    end else begin
                        state_d  = ST_DELIVER;
                        df_inj_d = 1'b0;
                    end
                end
            end
            ST_DELIVER, ST_NESTED: begin
                if (nest_valid) begin
                    if (vec_hit) begin
                        state_d = ST_EXIT_BITMAP;
                        svec_d  = (state_q == ST_DELIVER);
                        outc_d  = OC_BITMAP;
                    end else if (cur_contrib_q && vec_contrib) begin
                        state_d  = ST_DOUBLE;
                        df_inj_d = 1'b0;
                        entry_d  = 1'b1;
                        evec_d   = DF_V;
                        push_d   = !real_q;
                        pushv_d  = '0;
                    end else begin
                        state_d   = ST_NESTED;
                        entry_d   = 1'b1;
                        evec_d    = nest_vector;
                        push_d    = nest_has_ec && !real_q;
                        pushv_d   = {nest_ec[EC_W-1:1], ext_bit};
                        contrib_d = vec_contrib;
                    end
                end else if (dlv_ok) begin
                    state_d = ST_DONE;
                    outc_d  = OC_DELIVERED;
                end
            end
            ST_DOUBLE: begin
                if (nest_valid) begin
                    if (vec_hit) begin
                        state_d = ST_EXIT_BITMAP;
                        svec_d  = df_inj_q;
                        outc_d  = OC_BITMAP;
                    end else begin
                        state_d = ST_EXIT_TRIPLE;
                        svec_d  = 1'b0;
                        outc_d  = OC_TRIPLE;
                    end
                end else if (dlv_ok) begin
                    state_d = ST_DONE;
                    outc_d  = OC_DELIVERED;
                end
            end
            ST_EXIT_TRIPLE, ST_EXIT_BITMAP: begin
                state_d = ST_DONE;
            end
            ST_DONE: begin
                if (ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and injection context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            itype_q       <= '0;
            real_q        <= 1'b0;
            base_q        <= '0;
            cur_contrib_q <= 1'b0;
            df_inj_q      <= 1'b0;
            svec_q        <= 1'b0;
            outc_q        <= OC_DELIVERED;
        end else begin
            state_q       <= state_d;
            cur_contrib_q <= contrib_d;
            df_inj_q      <= df_inj_d;
            svec_q        <= svec_d;
            outc_q        <= outc_d;
            if (in_idle && inj_start && type_ok) begin
                itype_q <= inj_type;
                real_q  <= real_mode;
                base_q  <= table_base;
            end
        end
    end

    // Registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ec_push     <= 1'b0;
            ec_value    <= '0;
            entry_valid <= 1'b0;
            entry_addr  <= '0;
        end else begin
            ec_push     <= push_d;
            ec_value    <= push_d ? pushv_d : '0;
            entry_valid <= entry_d;
            entry_addr  <= entry_d ? addr_d : '0;
        end
    end

    // State-decoded outputs
    assign busy           = (state_q != ST_IDLE);
    assign exit_valid     = (state_q == ST_EXIT_TRIPLE) || (state_q == ST_EXIT_BITMAP);
    assign exit_triple    = (state_q == ST_EXIT_TRIPLE);
    assign save_vectoring = exit_valid && svec_q;
    assign done           = (state_q == ST_DONE);
    assign outcome        = outc_q;

    AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> (!exit_valid && done)); // R7

    AST_TRIPLE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT_TRIPLE) |-> ($past(state_q) == ST_DOUBLE)); // R7

    AST_DF_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_push && state_q == ST_DOUBLE &&
         ($past(state_q) == ST_DELIVER || $past(state_q) == ST_NESTED)) |-> (ec_value == '0)); // R6

    AST_SAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        save_vectoring |-> ($past(state_q) == ST_DELIVER || $past(state_q) == ST_DOUBLE)); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack) |=> done); // R12

    AST_INJ_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE && busy) |-> !exit_valid); // R3

endmodule

// File: tb/sim_evx_escalator.sv
module sim_evx_escalator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inj_start = 1'b0;
    logic [2:0]  inj_type = '0;
    logic [7:0]  inj_vector = '0;
    logic        inj_ec_req = 1'b0;
    logic [15:0] inj_ec = '0;
    logic        real_mode = 1'b0;
    logic [31:0] table_base = 32'h1000_0000;
    logic [31:0] exc_bitmap = '0;
    logic        nest_valid = 1'b0;
    logic [7:0]  nest_vector = '0;
    logic        nest_has_ec = 1'b0;
    logic [15:0] nest_ec = '0;
    logic        dlv_ok = 1'b0;
    logic        ack = 1'b0;
    logic        busy, ec_push, entry_valid, exit_valid, exit_triple, save_vectoring, done;
    logic [15:0] ec_value;
    logic [31:0] entry_addr;
    logic [1:0]  outcome;

    int nchk = 0;
    int nerr = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    evx_escalator u0 (
        .clk(clk), .rst_n(rst_n), .inj_start(inj_start), .inj_type(inj_type),
        .inj_vector(inj_vector), .inj_ec_req(inj_ec_req), .inj_ec(inj_ec),
        .real_mode(real_mode), .table_base(table_base), .exc_bitmap(exc_bitmap),
        .nest_valid(nest_valid), .nest_vector(nest_vector), .nest_has_ec(nest_has_ec),
        .nest_ec(nest_ec), .dlv_ok(dlv_ok), .ack(ack), .busy(busy), .ec_push(ec_push),
        .ec_value(ec_value), .entry_valid(entry_valid), .entry_addr(entry_addr),
        .exit_valid(exit_valid), .exit_triple(exit_triple),
        .save_vectoring(save_vectoring), .done(done), .outcome(outcome)
    );

    localparam logic [31:0] CMASK = 32'h0000_7C01;

    function automatic bit is_contrib(input int v);
        return (v < 32) && CMASK[v];
    endfunction

    function automatic logic exp_ext(input int t);
        return (t == 4 || t == 6) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
        end
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic start_ev(input int t, input int v, input bit ecreq, input logic [15:0] ec);
        inj_start = 1'b1; inj_type = 3'(t); inj_vector = 8'(v);
        inj_ec_req = ecreq; inj_ec = ec;
        tick();
        inj_start = 1'b0; inj_ec_req = 1'b0;
    endtask

    task automatic nest(input int v, input bit has, input logic [15:0] ec);
        nest_valid = 1'b1; nest_vector = 8'(v); nest_has_ec = has; nest_ec = ec;
        tick();
        nest_valid = 1'b0; nest_has_ec = 1'b0;
    endtask

    task automatic finish_ok();
        dlv_ok = 1'b1; tick(); dlv_ok = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 push", ec_push, 0);
        chk("R1 entry", entry_valid, 0);
        chk("R1 exit", {exit_valid, exit_triple, save_vectoring}, 0);

        // Type sweep: acceptance, injected push, EXT by level, priority, handshake
        for (int t = 0; t < 8; t++) begin
            for (int k = 0; k < 3; k++) begin
                int v;
                v = (k == 0) ? 3 : (k == 1) ? 6 : 40;
                exc_bitmap = '0;
                start_ev(t, v, 1'b1, 16'h1230);
                if (t == 1 || t == 7) begin
                    chk("R2 reserved ignored busy", busy, 0);
                    chk("R2 reserved no entry", entry_valid, 0);
                    continue;
                end
                chk("R2 accepted", busy, 1);
                chk("R3 entry strobe", entry_valid, 1);
                chk("R3 entry addr", entry_addr, table_base + 32'(8 * v));
                chk("R3 injected push", {ec_push, ec_value}, {1'b1, 16'h1230});
                chk("R3 no exit on inject", exit_valid, 0);
                nest(6, 1'b1, 16'h0abd);
                chk("R4 first EXT", {ec_push, ec_value}, {1'b1, 16'h0abc | 16'(exp_ext(t))});
                chk("R13 nested entry", entry_addr, table_base + 32'd48);
                nest(40, 1'b1, 16'h5554);
                chk("R5 deeper EXT", {ec_push, ec_value}, {1'b1, 16'h5555});
                nest(41, 1'b0, 16'h7777);
                chk("R13 no code no push", ec_push, 0);
                dlv_ok = 1'b1;
                nest(7, 1'b1, 16'h0002);
                dlv_ok = 1'b0;
                chk("R12 nested wins over dlv_ok", {done, entry_valid}, {1'b0, 1'b1});
                finish_ok();
                chk("R12 done delivered", {done, outcome}, {1'b1, 2'd0});
                tick();
                chk("R12 done held", done, 1);
                do_ack();
                chk("R12 idle after ack", busy, 0);
            end
        end

        // Bitmap sweep at first and second level
        for (int nv = 0; nv < 40; nv++) begin
            exc_bitmap = (nv < 32) ? (32'd1 << nv) : 32'hFFFF_FFFF;
            start_ev(0, 32, 1'b0, 16'h0);
            nest(nv, 1'b1, 16'h0010);
            if (nv < 32) begin
                chk("R9 bitmap exit", {exit_valid, exit_triple}, 2'b10);
                chk("R10 save on first", save_vectoring, 1);
                tick();
                chk("R9 outcome bitmap", {done, outcome, exit_valid}, {1'b1, 2'd1, 1'b0});
            end else begin
                chk("R9 high vector no hit", {exit_valid, ec_push}, 2'b01);
                nest(5, 1'b1, 16'h0010);
                chk("R9 second level exit", exit_valid, 1);
                chk("R10 no save second", save_vectoring, 0);
                tick();
            end
            do_ack();
        end

        // Injected NMI / hardware exception never exit
        exc_bitmap = 32'hFFFF_FFFF;
        start_ev(2, 2, 1'b0, 16'h0);
        chk("R3 NMI no exit", {busy, exit_valid}, 2'b10);
        tick();
        chk("R3 NMI still no exit", exit_valid, 0);
        finish_ok();
        chk("R3 NMI delivered", {done, outcome}, {1'b1, 2'd0});
        do_ack();

        // Contributory pair sweep
        exc_bitmap = '0;
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                bit df;
                if (a == 8) continue;
                df = is_contrib(a) && is_contrib(b);
                start_ev(3, a, 1'b0, 16'h0);
                nest(b, 1'b1, 16'h0010);
                if (df) begin
                    chk("R6 double fault code", {ec_push, ec_value}, {1'b1, 16'h0000});
                    chk("R6 double fault entry", entry_addr, table_base + 32'd64);
                    nest(6, 1'b1, 16'h0);
                    chk("R7 triple exit", {exit_valid, exit_triple, save_vectoring}, 3'b110);
                    tick();
                    chk("R7 triple outcome", {done, outcome}, {1'b1, 2'd2});
                end else begin
                    chk("R6 no double fault", {ec_push, ec_value}, {1'b1, 16'h0011});
                    chk("R6 nested entry", entry_addr, table_base + 32'(8 * b));
                    finish_ok();
                end
                do_ack();
            end
        end

        // Double fault at second level, then bitmap exit without save
        start_ev(4, 128, 1'b0, 16'h0);
        nest(13, 1'b1, 16'h0020);
        chk("R4 swint first EXT clear", ec_value, 16'h0020);
        nest(13, 1'b1, 16'h0020);
        chk("R6 deep double fault", {ec_push, ec_value}, {1'b1, 16'h0000});
        exc_bitmap = 32'h0000_0040;
        nest(6, 1'b0, 16'h0);
        chk("R10 deep exit no save", {exit_valid, exit_triple, save_vectoring}, 3'b100);
        tick();
        do_ack();

        // Injected double fault
        exc_bitmap = '0;
        start_ev(3, 8, 1'b1, 16'h0000);
        chk("R8 injected DF entry", entry_addr, table_base + 32'd64);
        nest(11, 1'b1, 16'h0);
        chk("R8 injected DF triple", {exit_valid, exit_triple}, 2'b11);
        tick();
        do_ack();
        exc_bitmap = 32'h0000_0800;
        start_ev(3, 8, 1'b0, 16'h0);
        nest(11, 1'b1, 16'h0);
        chk("R10 injected DF save", {exit_valid, exit_triple, save_vectoring}, 3'b101);
        tick();
        do_ack();
        exc_bitmap = '0;
        start_ev(3, 8, 1'b0, 16'h0);
        finish_ok();
        chk("R12 DF delivered", {done, outcome}, {1'b1, 2'd0});
        do_ack();

        // Real mode: narrow slots, no pushes
        real_mode = 1'b1;
        table_base = 32'h0000_0400;
        for (int v = 0; v < 16; v++) begin
            bit df;
            if (v == 8) continue;
            df = is_contrib(v) && is_contrib(13);
            start_ev(3, v, 1'b1, 16'h1111);
            chk("R11 no injected push", ec_push, 0);
            chk("R3 real entry", entry_addr, 32'h400 + 32'(4 * v));
            nest(13, 1'b1, 16'h2222);
            chk("R11 no nested push", ec_push, 0);
            chk("R11 real nested entry", entry_addr, 32'h400 + (df ? 32'd32 : 32'd52));
            finish_ok();
            do_ack();
        end
        real_mode = 1'b0;

        summary();
    end

endmodule